// File: doc/BRIEF.md
# Pre-driver fault status and interrupt register block

This block is the control-side register file of a three-phase gate pre-driver. A host reaches it over an 8-bit SPI slave port. Each command byte can ask for one of four status views, load half of an interrupt mask, write the mode nibble, or clear one nibble of latched faults. The analog side reports fault events as one-cycle pulses. The block latches each event into a sticky fault register and raises an interrupt whenever a latched fault is not masked.

The reply to a command is not returned in the same transfer. The block captures the reply at the end of the command frame and shifts it out during the next frame, so a host always reads one frame behind. Mode writes are accepted only until a mode byte with the lock bit set arrives. After that, mode writes are ignored until reset. The gate-drive enable output needs both external enable pins high and the mode locked.

SPI runs in mode 0 (data sampled on the rising SCLK edge, changed on the falling edge), MSB first. SCLK, chip select and MOSI are oversampled in the system clock domain through two-stage synchronizers.

Top module: `pdrv_status_spi`

## Requirements
- R1: Framing. A frame is cs_n low, then exactly 8 SCLK rising edges, then cs_n high. MOSI is sampled MSB first, and the first reply bit appears on MISO after cs_n falls. A command takes effect at the fourth rising clk edge after cs_n rises.
- R2: The byte shifted out on MISO in a frame is the reply captured for the previous valid frame. The first frame after reset shifts out 0x00.
- R3: A byte 0000_00nn is a read. nn=0 returns the fault register, nn=1 the mask, nn=2 {4'b0, mode}, and nn=3 {4'b0, en_a, en_b, drv_en, irq}. The reply is captured before the command's own register effects.
- R4: A pulse on fault_evt[k] sets fault bit k+1. Fault bits stay set until cleared, and no fault bit sets without an event.
- R5: Reset leaves the fault register at 0x01 (bit 0 is the reset-event flag), so irq is high from the first clock after reset.
- R6: 0010_xxxx loads mask[3:0] and 0011_xxxx loads mask[7:4] from the low nibble. The mask resets to 0x00.
- R7: irq is registered and equals the OR of (fault & ~mask) from one clock earlier.
- R8: 0110_xxxx clears fault bits 3:0 and 0111_xxxx clears fault bits 7:4. The other nibble is kept.
- R9: A fault event in the same clock as a clear of its bit leaves the bit set.
- R10: 0100_xxxx writes mode[3:0]. Once mode[0] (lock) is 1, later mode writes are ignored until reset.
- R11: drv_en is registered and equals en_a & en_b & mode[0]. It is 0 during and right after reset.
- R12: A frame with fewer or more than 8 SCLK edges is discarded. No command runs and the pending reply is kept for the next frame.
- R13: Any byte not listed above changes no register, and its reply is the fault register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data in, MSB first |
| miso | output | 1 | SPI data out, deferred reply |
| fault_evt | input | 7 | One-cycle fault event pulses, bit k sets fault bit k+1 |
| en_a | input | 1 | First external drive-enable pin |
| en_b | input | 1 | Second external drive-enable pin |
| irq | output | 1 | Interrupt, high while an unmasked fault is latched |
| drv_en | output | 1 | Gate-drive enable |

## Verification
The bench times a fault pulse to land in exactly the clock that a nibble clear executes. A design that let the clear win would lose that fault bit. It sends frames of 5 and 9 clocks. A design that counted loosely would run the clear or advance the reply pipeline, and the next frame would return the wrong byte. It sweeps every nibble mask value against a full fault register, which catches a swapped or inverted mask half through a wrong irq level. It also tries a mode write after lock, which a design without the freeze would accept and show on the mode readback. The bench then checks that a second reset releases the lock.

// File: rtl/pdrv_spi_pkg.sv
package pdrv_spi_pkg;

    localparam int FRAME_W  = 8;
    localparam int NIB_W    = FRAME_W / 2;
    localparam int NFLT     = FRAME_W - 1;
    localparam int CNT_MAX  = FRAME_W + 1;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int LOCK_BIT = 0;

    typedef logic [FRAME_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]   nib_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_READ,
        OP_MASK_LO,
        OP_MASK_HI,
        OP_MODE,
        OP_CLR_LO,
        OP_CLR_HI
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [1:0] sel;
        nib_t       arg;
    } cmd_t;

    localparam logic [1:0] SEL_FAULT = 2'd0;
    localparam logic [1:0] SEL_MASK  = 2'd1;
    localparam logic [1:0] SEL_MODE  = 2'd2;
    localparam logic [1:0] SEL_PINS  = 2'd3;

    localparam byte_t RST_FAULTS = byte_t'(1);

    function automatic cmd_t decode_cmd(input byte_t b);
        cmd_t c;
        c.op  = OP_IDLE;
        c.sel = SEL_FAULT;
        c.arg = b[NIB_W-1:0];
        case (b[FRAME_W-1:NIB_W])
            4'h0: begin
                if (b[NIB_W-1:2] == '0) begin
                    c.op  = OP_READ;
                    c.sel = b[1:0];
                end
            end
            4'h2:    c.op = OP_MASK_LO;
            4'h3:    c.op = OP_MASK_HI;
            4'h4:    c.op = OP_MODE;
            4'h6:    c.op = OP_CLR_LO;
            4'h7:    c.op = OP_CLR_HI;
            default: c.op = OP_IDLE;
        endcase
        return c;
    endfunction

    function automatic byte_t group_bits(input logic hi);
        byte_t g;
        g = '0;
        if (hi) g[FRAME_W-1:NIB_W] = '1;
        else    g[NIB_W-1:0]       = '1;
        return g;
    endfunction

endpackage

// File: rtl/pdrv_spi_port.sv
module pdrv_spi_port
    import pdrv_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk,
    input  logic  cs_n,
    input  logic  mosi,
    output logic  miso,
    input  byte_t tx_load,
    output logic  frame_ok,
    output byte_t frame_byte
);

    logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
    logic sclk_s, cs_s, mosi_s;
    logic sclk_d, cs_d;
    logic sck_rise, sck_fall, cs_fall, cs_rise;
    byte_t rx_q, tx_q;
    logic [CNT_W-1:0] cnt_q;
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sync <= '0;
            cs_sync   <= '1;
            mosi_sync <= '0;
        end else begin
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
            cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
        end
    end

    assign sclk_s   = sclk_sync[SYNC_STAGES-1];
    assign cs_s     = cs_sync[SYNC_STAGES-1];
    assign mosi_s   = mosi_sync[SYNC_STAGES-1];
    assign sck_rise = sclk_s & ~sclk_d;
    assign sck_fall = ~sclk_s & sclk_d;
    assign cs_fall  = ~cs_s & cs_d;
    assign cs_rise  = cs_s & ~cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d     <= 1'b0;
            cs_d       <= 1'b1;
            rx_q       <= '0;
            tx_q       <= '0;
            cnt_q      <= '0;
            frame_ok   <= 1'b0;
            frame_byte <= '0;
            past_ok    <= 1'b0;
        end else begin
            past_ok  <= 1'b1;
            sclk_d   <= sclk_s;
            cs_d     <= cs_s;
            frame_ok <= 1'b0;
            if (cs_fall) begin
                tx_q  <= tx_load;
                cnt_q <= '0;
            end else if (!cs_s) begin
                if (sck_rise) begin
                    rx_q <= {rx_q[FRAME_W-2:0], mosi_s};
                    if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
                end
                if (sck_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end
            if (cs_rise) begin
                frame_ok   <= (cnt_q == CNT_W'(FRAME_W));
                frame_byte <= rx_q;
            end
        end
    end

    assign miso = tx_q[FRAME_W-1] & ~cs_s;

    // R12: a frame is only accepted at the close of chip select
    a_r12_done_on_cs_rise: assert property (@(posedge clk) disable iff (rst || !past_ok)
        frame_ok |-> ($past(cs_s) && !$past(cs_d)));

    // R1: the bit counter never runs past its saturation value
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CNT_MAX));

    // R1: the shifter only moves while selected
    a_r1_rx_idle_when_deselected: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(cs_s) |-> $stable(rx_q));

endmodule

// File: rtl/pdrv_fault_bank.sv
module pdrv_fault_bank
    import pdrv_spi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NFLT-1:0] fault_evt,
    input  byte_t           clr_mask,
    input  byte_t           irq_mask,
    output byte_t           status,
    output logic            irq
);

    byte_t set_vec;
    logic  past_ok;

    assign set_vec = {fault_evt, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            status  <= RST_FAULTS;
            irq     <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            status  <= (status & ~clr_mask) | set_vec;
            irq     <= |(status & ~irq_mask);
        end
    end

    // R4: latched bits survive every cycle without a clear
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(status) & ~$past(clr_mask) & ~status) == '0);

    // R4: no bit rises without an event
    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (status & ~$past(status) & ~$past(set_vec)) == '0);

    // R9: an event always lands, even against a clear
    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(set_vec) & ~status) == '0);

    // R7: interrupt follows the unmasked faults one clock later
    a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst || !past_ok)
        irq == |($past(status) & ~$past(irq_mask)));

endmodule

// File: rtl/pdrv_cfg_regs.sv
module pdrv_cfg_regs
    import pdrv_spi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_valid,
    input  cmd_t  cmd,
    input  logic  en_a,
    input  logic  en_b,
    output byte_t irq_mask,
    output nib_t  mode,
    output logic  drv_en
);

    nib_t mask_nib [2];
    logic past_ok;

    for (genvar g = 0; g < 2; g++) begin : g_mask_half
        localparam op_e LOAD_OP = (g == 0) ? OP_MASK_LO : OP_MASK_HI;
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_nib[g] <= '0;
            end else if (cmd_valid && cmd.op == LOAD_OP) begin
                mask_nib[g] <= cmd.arg;
            end
        end
    end

    assign irq_mask = {mask_nib[1], mask_nib[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= '0;
            drv_en  <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (cmd_valid && cmd.op == OP_MODE && !mode[LOCK_BIT]) mode <= cmd.arg;
            drv_en <= en_a & en_b & mode[LOCK_BIT];
        end
    end

    // R10: once locked the mode nibble is frozen
    a_r10_lock_hold: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(mode[LOCK_BIT]) |-> $stable(mode));

    // R11: drive enable only follows both pins and the lock
    a_r11_drv_gate: assert property (@(posedge clk) disable iff (rst || !past_ok)
        drv_en |-> $past(en_a && en_b && mode[LOCK_BIT]));

    // R6: mask moves only on an accepted command
    a_r6_mask_by_cmd: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$past(cmd_valid) |-> $stable(irq_mask));

endmodule

// File: rtl/pdrv_status_spi.sv
module pdrv_status_spi
    import pdrv_spi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            mosi,
    output logic            miso,
    input  logic [NFLT-1:0] fault_evt,
    input  logic            en_a,
    input  logic            en_b,
    output logic            irq,
    output logic            drv_en
);

    logic  frame_ok;
    byte_t frame_byte;
    cmd_t  cmd;
    byte_t clr_mask;
    byte_t status;
    byte_t irq_mask;
    nib_t  mode;
    byte_t reply_q;
    byte_t reply_d;
    logic  past_ok;

    assign cmd = decode_cmd(frame_byte);

    always_comb begin
        clr_mask = '0;
        if (frame_ok) begin
            if (cmd.op == OP_CLR_LO) clr_mask = group_bits(1'b0);
            if (cmd.op == OP_CLR_HI) clr_mask = group_bits(1'b1);
        end
    end

    always_comb begin
        reply_d = status;
        if (cmd.op == OP_READ) begin
            case (cmd.sel)
                SEL_MASK: reply_d = irq_mask;
                SEL_MODE: reply_d = {{(FRAME_W-NIB_W){1'b0}}, mode};
                SEL_PINS: reply_d = {{(FRAME_W-4){1'b0}}, en_a, en_b, drv_en, irq};
                default:  reply_d = status;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reply_q <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (frame_ok) reply_q <= reply_d;
        end
    end

    pdrv_spi_port #(.SYNC_STAGES(2)) spi_i (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .miso       (miso),
        .tx_load    (reply_q),
        .frame_ok   (frame_ok),
        .frame_byte (frame_byte)
    );

    pdrv_fault_bank fault_i (
        .clk       (clk),
        .rst       (rst),
        .fault_evt (fault_evt),
        .clr_mask  (clr_mask),
        .irq_mask  (irq_mask),
        .status    (status),
        .irq       (irq)
    );

    pdrv_cfg_regs cfg_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (frame_ok),
        .cmd       (cmd),
        .en_a      (en_a),
        .en_b      (en_b),
        .irq_mask  (irq_mask),
        .mode      (mode),
        .drv_en    (drv_en)
    );

    // R12: the pending reply only changes on an accepted frame
    a_r12_reply_held: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$past(frame_ok) |-> $stable(reply_q));

    // R8: a clear never touches both nibbles at once
    a_r8_one_group: assert property (@(posedge clk) disable iff (rst)
        $countones(clr_mask) == 0 || $countones(clr_mask) == NIB_W);

endmodule

// File: tb/pdrv_status_spi_tb_top.sv
module pdrv_status_spi_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic [6:0] fault_evt = '0;
    logic en_a = 1'b0;
    logic en_b = 1'b0;
    logic irq, drv_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] m_sr0, m_mask, m_pend;
    logic [3:0] m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdrv_status_spi dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .fault_evt(fault_evt), .en_a(en_a), .en_b(en_b), .irq(irq), .drv_en(drv_en)
    );

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check1(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_sr0 = 8'h01; m_mask = 8'h00; m_mode = 4'h0; m_pend = 8'h00;
    endtask

    task automatic model_apply(input logic [7:0] cmd, input logic [6:0] pulse);
        logic [7:0] nxt;
        nxt = m_sr0;
        if (cmd[7:2] == 6'b0) begin
            case (cmd[1:0])
                2'd0: nxt = m_sr0;
                2'd1: nxt = m_mask;
                2'd2: nxt = {4'h0, m_mode};
                default: nxt = {4'h0, en_a, en_b, en_a & en_b & m_mode[0], |(m_sr0 & ~m_mask)};
            endcase
        end
        case (cmd[7:4])
            4'h2: m_mask[3:0] = cmd[3:0];
            4'h3: m_mask[7:4] = cmd[3:0];
            4'h4: if (!m_mode[0]) m_mode = cmd[3:0];
            4'h6: m_sr0[3:0] = 4'h0;
            4'h7: m_sr0[7:4] = 4'h0;
            default: ;
        endcase
        m_sr0  = m_sr0 | {pulse, 1'b0};
        m_pend = nxt;
    endtask

    task automatic xfer(input logic [7:0] cmd, input int nclk, input logic [6:0] pulse,
                        output logic [7:0] got);
        got = 8'h00;
        @(negedge clk) cs_n = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 8) ? cmd[7-i] : 1'b0;
            repeat (HALF_SCK) @(negedge clk);
            if (i < 8) got[7-i] = miso;
            sclk = 1'b1;
            repeat (HALF_SCK) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF_SCK) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        fault_evt = pulse;
        @(negedge clk);
        fault_evt = '0;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_cmd_p(input logic [7:0] cmd, input logic [6:0] pulse, input string tag);
        logic [7:0] got;
        xfer(cmd, 8, pulse, got);
        check8({tag, " R2 reply"}, got, m_pend);
        model_apply(cmd, pulse);
    endtask

    task automatic do_cmd(input logic [7:0] cmd, input string tag);
        do_cmd_p(cmd, 7'd0, tag);
    endtask

    task automatic pulse_fault(input int k);
        @(negedge clk) fault_evt[k] = 1'b1;
        @(negedge clk) fault_evt = '0;
        m_sr0[k+1] = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk) rst = 1'b1;
        repeat (4) @(negedge clk);
        check1("R5 irq low in reset", irq, 1'b0);
        check1("R11 drv_en low in reset", drv_en, 1'b0);
        rst = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        apply_reset();
        check1("R5 irq after reset", irq, 1'b1);
        check1("R11 drv_en after reset", drv_en, 1'b0);
        check1("R1 miso idle", miso, 1'b0);

        // R2 first reply is zero, R3 views
        do_cmd(8'h01, "R1 R3 read mask");
        do_cmd(8'h02, "R3 read mode");
        do_cmd(8'h03, "R3 read pins");
        do_cmd(8'h00, "R3 R5 read faults");

        // R8 clear low nibble drops reset flag
        do_cmd(8'h60, "R8 clint0");
        check1("R7 irq after clear", irq, 1'b0);

        // R4 each event latches its own bit
        for (int k = 0; k < 7; k++) begin
            pulse_fault(k);
            check1("R7 irq on event", irq, 1'b1);
            do_cmd(8'h00, "R4 sticky read");
        end
        do_cmd(8'h00, "R4 all bits");

        // R8 clear high nibble only
        do_cmd(8'h7A, "R8 clint1");
        do_cmd(8'h00, "R8 low kept");
        do_cmd(8'h00, "R8 readback");

        // R9 event in the clear cycle
        do_cmd_p(8'h6F, 7'b0000010, "R9 clear with event");
        do_cmd(8'h00, "R9 readback");
        do_cmd(8'h00, "R9 bit kept");

        // R6 R7 mask sweep against a full fault register
        for (int k = 0; k < 7; k++) pulse_fault(k);
        for (int m = 0; m < 16; m++) begin
            do_cmd(8'h20 | 8'(m), "R6 mask lo");
            do_cmd(8'h30 | 8'(m), "R6 mask hi");
            check1("R7 irq vs mask", irq, |(m_sr0 & ~m_mask));
            do_cmd(8'h01, "R6 read mask");
        end
        do_cmd(8'h20, "R6 mask lo zero");
        do_cmd(8'h30, "R6 mask hi zero");
        do_cmd(8'h01, "R6 mask cleared");

        // R13 unlisted bytes
        do_cmd(8'h04, "R13 0x04");
        do_cmd(8'h1F, "R13 0x1F");
        do_cmd(8'h5C, "R13 0x5C");
        do_cmd(8'h80, "R13 0x80");
        do_cmd(8'hFF, "R13 0xFF");
        do_cmd(8'h01, "R13 mask intact");
        do_cmd(8'h02, "R13 mode intact");
        do_cmd(8'h00, "R13 faults intact");

        // R12 short and long frames
        xfer(8'h60, 5, 7'd0, got);
        check8("R12 short frame leading bits", {got[7:3], 3'b0}, {m_pend[7:3], 3'b0});
        xfer(8'h70, 9, 7'd0, got);
        check8("R12 long frame reply", got, m_pend);
        do_cmd(8'h00, "R12 pipeline kept");
        do_cmd(8'h00, "R12 no clear ran");

        // R10 R11 mode and lock
        @(negedge clk) begin en_a = 1'b1; en_b = 1'b1; end
        do_cmd(8'h46, "R10 mode write");
        check1("R11 drv_en unlocked", drv_en, 1'b0);
        do_cmd(8'h4A, "R10 mode rewrite");
        do_cmd(8'h45, "R10 mode lock");
        check1("R11 drv_en locked", drv_en, 1'b1);
        do_cmd(8'h4E, "R10 write after lock");
        do_cmd(8'h02, "R10 read mode");
        do_cmd(8'h03, "R11 read pins");
        @(negedge clk) en_b = 1'b0;
        repeat (3) @(negedge clk);
        check1("R11 drv_en pin low", drv_en, 1'b0);
        do_cmd(8'h03, "R11 pins view");
        do_cmd(8'h00, "R11 flush");

        // R5 R10 second reset releases lock
        @(negedge clk) en_b = 1'b1;
        apply_reset();
        check1("R5 irq second reset", irq, 1'b1);
        check1("R11 drv_en after second reset", drv_en, 1'b0);
        do_cmd(8'h48, "R2 first reply after reset");
        do_cmd(8'h02, "R10 unlocked after reset");
        do_cmd(8'h00, "R10 mode readback");

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule